// File: doc/BRIEF.md
# NAND Two-Phase Access Sequencer

This block sits between a simple memory-mapped host port and an 8-bit NAND flash pin bus, and turns each host transfer into a burst of flash bus cycles. It takes everything it needs for a transfer from the host address: the target chip, whether the transfer is a command phase or a data phase, the opcode bytes, how many address bytes to send, and whether to drop chip enable at the end. No control registers are involved.

A command phase sends an opcode latched with CLE. It then sends up to four address bytes latched with ALE, taken from the write data, and can close with a second opcode. A data phase moves one host word of four bytes to or from the device. It can also close with an opcode, and it may release chip enable. After any closing opcode the block treats the device as busy. It does not start the next data phase until a fixed settle delay has passed and the ready/busy pin reads high. Write and read strobes use fixed pulse widths.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset all chip enables are high (inactive), both strobes are high, CLE and ALE are low and `h_ready` is low.
- R2: Bit 19 of `h_addr` selects the phase: 0 is a command phase and 1 is a data phase. The low log2(NUM_CHIPS) bits of `h_addr[31:24]` pick which `nand_ce_n` bit goes low, and the upper bits of that field are ignored. At most one chip enable is low at any time.
- R3: A command phase first latches the byte `h_addr[10:3]` with CLE high and ALE low. A command phase ignores `h_write`.
- R4: After the opening opcode, a command phase sends N address bytes with ALE high and CLE low. N is `h_addr[23:21]`, capped at 4. The bytes are taken from `h_wdata` starting with bits [7:0].
- R5: In either phase, when `h_addr[20]` is 1, the last latched byte is `h_addr[18:11]` with CLE high. When it is 0, no closing opcode is sent.
- R6: A data-phase write (`h_write`=1) latches the four bytes of `h_wdata` starting with bits [7:0], with CLE and ALE low.
- R7: A data-phase read (`h_write`=0) issues exactly four read strobes and no write-data strobes. The first byte read lands in `h_rdata[7:0]`, and the full word is valid while `h_ready` is high.
- R8: A data phase with `h_addr[21]`=1 leaves all chip enables high once it completes. Without that bit, and after any command phase, the selected chip enable stays low between transfers.
- R9: After a closing opcode, the next data phase sends no strobe while `nand_rb` is low. It waits at least RB_SETTLE cycles and then for `nand_rb` high.
- R10: Each write or read strobe stays low for exactly LO_CYC cycles and high for at least HI_CYC cycles. The two strobes are never low together.
- R11: `h_ready` is a single-cycle pulse, given once per accepted host transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_valid | input | 1 | Host request valid, held until `h_ready` |
| h_ready | output | 1 | One-cycle completion pulse |
| h_write | input | 1 | Data-phase direction, 1 = write to flash |
| h_addr | input | ADDR_W | Transfer address carrying phase, chip, opcodes and flags |
| h_wdata | input | DATA_W | Address bytes (command phase) or write data (data phase) |
| h_rdata | output | DATA_W | Read data, valid with `h_ready` |
| nand_ce_n | output | NUM_CHIPS | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| nand_dq_o | output | 8 | Flash data bus output |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Flash data bus input |

## Verification
A wrong state in the sequencer shows up on the flash bus within one byte slot, which is about five cycles. It appears as a byte latched with the wrong CLE/ALE qualifier, an opcode or address byte out of order, or a missing or extra byte in a transfer. A bad byte index shows up as swapped lanes in the write bytes or in `h_rdata`, and this is visible once that transfer's `h_ready` arrives. A corrupt chip-enable register shows up on `nand_ce_n` one cycle after completion, or at the next strobe. A lost busy flag shows up as a strobe during a period when `nand_rb` is low.

// File: rtl/nps_pkg.sv
package nps_pkg;

   // field positions in the host address; neighbours rely on these
   localparam int CHIP_LSB  = 24;
   localparam int NADR_LSB  = 21;
   localparam int NADR_W    = 3;
   localparam int RELS_BIT  = 21;
   localparam int ENDV_BIT  = 20;
   localparam int PHASE_BIT = 19;
   localparam int ENDC_LSB  = 11;
   localparam int STC_LSB   = 3;

   typedef struct packed {
      logic              data_ph;
      logic [7:0]        chip;
      logic [7:0]        open_op;
      logic [NADR_W-1:0] nadr;
      logic              close_v;
      logic [7:0]        close_op;
      logic              drop_ce;
   } req_t;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_RBW, SQ_OPEN, SQ_ADR, SQ_DAT, SQ_CLOSE, SQ_FIN
   } seq_st_t;

   function automatic req_t decode_req(input logic [31:0] a);
      req_t r;
      r.data_ph  = a[PHASE_BIT];
      r.chip     = a[CHIP_LSB +: 8];
      r.open_op  = a[STC_LSB +: 8];
      r.nadr     = a[NADR_LSB +: NADR_W];
      r.close_v  = a[ENDV_BIT];
      r.close_op = a[ENDC_LSB +: 8];
      r.drop_ce  = a[PHASE_BIT] & a[RELS_BIT];
      return r;
   endfunction

endpackage

// File: rtl/nps_strobe_timer.sv
module nps_strobe_timer #(
   parameter int LO_CYC = 2,
   parameter int HI_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rd,
   output logic busy,
   output logic sample,
   output logic done,
   output logic we_n,
   output logic re_n
);
   localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   logic          low_q;
   logic          rd_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         low_q <= 1'b0;
         rd_q  <= 1'b0;
         cnt_q <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            low_q <= 1'b1;
            rd_q  <= rd;
            cnt_q <= CW'(LO_CYC - 1);
         end
      end else if (low_q) begin
         if (cnt_q == '0) begin
            low_q <= 1'b0;
            cnt_q <= CW'(HI_CYC - 1);
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end else begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign sample = busy &  low_q & (cnt_q == '0);
   assign done   = busy & ~low_q & (cnt_q == '0);
   assign we_n   = ~(busy & low_q & ~rd_q);
   assign re_n   = ~(busy & low_q &  rd_q);

endmodule

// File: rtl/nps_ce_ctrl.sv
module nps_ce_ctrl #(
   parameter int NUM_CHIPS = 4,
   parameter int CHIP_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic [CHIP_W-1:0]    take_chip,
   input  logic                 drop,
   output logic [NUM_CHIPS-1:0] ce_n
);
   logic              on_q;
   logic [CHIP_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         sel_q <= '0;
      end else if (take) begin
         on_q  <= 1'b1;
         sel_q <= take_chip;
      end else if (drop) begin
         on_q  <= 1'b0;
      end
   end

   for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_ce
      assign ce_n[i] = ~(on_q && (sel_q == CHIP_W'(i)));
   end

endmodule

// File: rtl/nps_busy_guard.sv
module nps_busy_guard #(
   parameter int RB_SETTLE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic clear,
   input  logic rb,
   output logic pending,
   output logic go
);
   localparam int SW = $clog2(RB_SETTLE + 1);

   logic [SW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         cnt_q   <= '0;
      end else begin
         if (arm) begin
            pending <= 1'b1;
            cnt_q   <= SW'(RB_SETTLE);
         end else begin
            if (clear) pending <= 1'b0;
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign go = ~pending | ((cnt_q == '0) & rb);

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int NUM_CHIPS = 4,
   parameter int LO_CYC    = 2,
   parameter int HI_CYC    = 2,
   parameter int RB_SETTLE = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 h_valid,
   output logic                 h_ready,
   input  logic                 h_write,
   input  logic [ADDR_W-1:0]    h_addr,
   input  logic [DATA_W-1:0]    h_wdata,
   output logic [DATA_W-1:0]    h_rdata,
   output logic [NUM_CHIPS-1:0] nand_ce_n,
   output logic                 nand_cle,
   output logic                 nand_ale,
   output logic                 nand_we_n,
   output logic                 nand_re_n,
   input  logic                 nand_rb,
   output logic [7:0]           nand_dq_o,
   output logic                 nand_dq_oe,
   input  logic [7:0]           nand_dq_i
);
   import nps_pkg::*;

   localparam int BEATS  = DATA_W / 8;
   localparam int BSEL_W = $clog2(BEATS);
   localparam int CNT_W  = (BSEL_W + 1 > NADR_W) ? BSEL_W + 1 : NADR_W;
   localparam int CHIP_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;

   if (ADDR_W < 32) begin : g_bad_addr
      $error("ADDR_W must be at least 32");
   end
   if ((DATA_W % 8) != 0 || DATA_W < 16 || DATA_W > 64) begin : g_bad_data
      $error("DATA_W must be a byte multiple between 16 and 64");
   end
   if (NUM_CHIPS < 1 || NUM_CHIPS > 256) begin : g_bad_chips
      $error("NUM_CHIPS must be 1..256");
   end
   if (LO_CYC < 1 || HI_CYC < 1 || RB_SETTLE < 1) begin : g_bad_timing
      $error("strobe widths and settle delay must be at least 1");
   end

   seq_st_t             st_q;
   req_t                rq_q;
   req_t                rq_in;
   logic [CNT_W-1:0]    nadr_q;
   logic                wr_q;
   logic [DATA_W-1:0]   wd_q;
   logic [DATA_W-1:0]   rbuf_q;
   logic [CNT_W-1:0]    bidx_q;
   logic [BSEL_W-1:0]   bsel;

   logic tmr_start, tmr_busy, tmr_sample, tmr_done;
   logic byte_st, accept, last_adr, last_dat;
   logic grd_pending, grd_go, grd_arm, grd_clear;

   assign rq_in  = decode_req(h_addr[31:0]);
   assign bsel   = bidx_q[BSEL_W-1:0];
   assign accept = (st_q == SQ_IDLE) && h_valid;

   assign byte_st  = (st_q == SQ_OPEN) || (st_q == SQ_ADR) ||
                     (st_q == SQ_DAT)  || (st_q == SQ_CLOSE);
   assign tmr_start = byte_st && !tmr_busy;
   assign last_adr  = (bidx_q == nadr_q - 1'b1);
   assign last_dat  = (bidx_q == CNT_W'(BEATS - 1));
   assign grd_arm   = (st_q == SQ_CLOSE) && tmr_done;
   assign grd_clear = (st_q == SQ_RBW) && grd_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         rq_q   <= '0;
         nadr_q <= '0;
         wr_q   <= 1'b0;
         wd_q   <= '0;
         rbuf_q <= '0;
         bidx_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: if (h_valid) begin
               rq_q   <= rq_in;
               wr_q   <= h_write;
               wd_q   <= h_wdata;
               bidx_q <= '0;
               nadr_q <= (CNT_W'(rq_in.nadr) > CNT_W'(BEATS)) ? CNT_W'(BEATS)
                                                                : CNT_W'(rq_in.nadr);
               if (!rq_in.data_ph)  st_q <= SQ_OPEN;
               else if (grd_pending) st_q <= SQ_RBW;
               else                 st_q <= SQ_DAT;
            end
            SQ_RBW: if (grd_go) st_q <= SQ_DAT;
            SQ_OPEN: if (tmr_done) begin
               if (nadr_q != '0)     st_q <= SQ_ADR;
               else if (rq_q.close_v) st_q <= SQ_CLOSE;
               else                  st_q <= SQ_FIN;
            end
            SQ_ADR: if (tmr_done) begin
               if (last_adr) st_q <= rq_q.close_v ? SQ_CLOSE : SQ_FIN;
               else          bidx_q <= bidx_q + 1'b1;
            end
            SQ_DAT: begin
               if (tmr_sample && !wr_q) rbuf_q[bsel*8 +: 8] <= nand_dq_i;
               if (tmr_done) begin
                  if (last_dat) st_q <= rq_q.close_v ? SQ_CLOSE : SQ_FIN;
                  else          bidx_q <= bidx_q + 1'b1;
               end
            end
            SQ_CLOSE: if (tmr_done) st_q <= SQ_FIN;
            SQ_FIN:  st_q <= SQ_IDLE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      nand_dq_o = 8'h00;
      case (st_q)
         SQ_OPEN:  nand_dq_o = rq_q.open_op;
         SQ_CLOSE: nand_dq_o = rq_q.close_op;
         SQ_ADR,
         SQ_DAT:   nand_dq_o = wd_q[bsel*8 +: 8];
         default:  nand_dq_o = 8'h00;
      endcase
   end

   assign nand_cle   = (st_q == SQ_OPEN) || (st_q == SQ_CLOSE);
   assign nand_ale   = (st_q == SQ_ADR);
   assign nand_dq_oe = nand_cle || nand_ale || ((st_q == SQ_DAT) && wr_q);
   assign h_ready    = (st_q == SQ_FIN);
   assign h_rdata    = rbuf_q;

   nps_strobe_timer #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tmr_start),
      .rd     ((st_q == SQ_DAT) && !wr_q),
      .busy   (tmr_busy),
      .sample (tmr_sample),
      .done   (tmr_done),
      .we_n   (nand_we_n),
      .re_n   (nand_re_n)
   );

   nps_ce_ctrl #(.NUM_CHIPS(NUM_CHIPS), .CHIP_W(CHIP_W)) u_ce (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (accept),
      .take_chip (rq_in.chip[CHIP_W-1:0]),
      .drop      ((st_q == SQ_FIN) && rq_q.drop_ce),
      .ce_n      (nand_ce_n)
   );

   nps_busy_guard #(.RB_SETTLE(RB_SETTLE)) u_grd (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (grd_arm),
      .clear   (grd_clear),
      .rb      (nand_rb),
      .pending (grd_pending),
      .go      (grd_go)
   );

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
   parameter int NUM_CHIPS = 4,
   parameter int LO_CYC    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 h_ready,
   input logic [NUM_CHIPS-1:0] nand_ce_n,
   input logic                 nand_cle,
   input logic                 nand_ale,
   input logic                 nand_we_n,
   input logic                 nand_re_n,
   input logic                 nand_dq_oe
);
   logic [7:0] we_lo_len, re_lo_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_len <= '0;
         re_lo_len <= '0;
      end else begin
         we_lo_len <= nand_we_n ? 8'd0 : we_lo_len + 8'd1;
         re_lo_len <= nand_re_n ? 8'd0 : re_lo_len + 8'd1;
      end
   end

   // R10
   no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   // R10
   we_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> (we_lo_len == 8'(LO_CYC)));

   // R10
   re_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_re_n) |-> (re_lo_len == 8'(LO_CYC)));

   // R2
   ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~nand_ce_n));

   // R3
   cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nand_cle |-> !nand_ale);

   // R11
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_ready |=> !h_ready);

   // R8
   strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> ($countones(~nand_ce_n) == 1));

   // R7
   read_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_dq_oe);

endmodule

bind nand_phase_seq nps_checker #(.NUM_CHIPS(NUM_CHIPS), .LO_CYC(LO_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .h_ready    (h_ready),
   .nand_ce_n  (nand_ce_n),
   .nand_cle   (nand_cle),
   .nand_ale   (nand_ale),
   .nand_we_n  (nand_we_n),
   .nand_re_n  (nand_re_n),
   .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_phase_seq_bench.sv
module nand_phase_seq_bench;
   localparam int CLK_P = 10;
   localparam int NC    = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_valid = 1'b0;
   logic        h_ready;
   logic        h_write = 1'b0;
   logic [31:0] h_addr = '0;
   logic [31:0] h_wdata = '0;
   logic [31:0] h_rdata;
   logic [NC-1:0] nand_ce_n;
   logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic        nand_rb = 1'b1;
   logic [7:0]  nand_dq_o;
   logic [7:0]  nand_dq_i = '0;

   always #(CLK_P/2) clk = ~clk;

   nand_phase_seq #(.NUM_CHIPS(NC)) u_nand_phase_seq (
      .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
      .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb(nand_rb),
      .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // bus monitor and flash model
   logic        log_cle [0:31];
   logic        log_ale [0:31];
   logic [7:0]  log_dq  [0:31];
   logic [NC-1:0] log_ce [0:31];
   int          log_n = 0;
   int          re_cnt = 0;
   int          rd_ctr = 0;
   int          busy_cnt = 0;
   bit          watch_rb = 0;
   bit          rb_viol = 0;
   int          width_bad = 0;
   logic        prev_we = 1'b1, prev_re = 1'b1;
   int          lo_len = 0, hi_len = 0;

   function automatic logic [7:0] rd_byte(input int n);
      return 8'((n * 37 + 5) & 255);
   endfunction

   always @(negedge clk) begin
      if (prev_we && !nand_we_n || prev_re && !nand_re_n) begin
         if (hi_len < 2 && log_n + re_cnt > 0) width_bad++;
      end
      if (!nand_we_n || !nand_re_n) begin lo_len++; hi_len = 0; end
      else hi_len++;
      if (!prev_we && nand_we_n) begin
         if (lo_len != 2) width_bad++;
         lo_len = 0;
         if (log_n < 32) begin
            log_cle[log_n] = nand_cle; log_ale[log_n] = nand_ale;
            log_dq[log_n]  = nand_dq_o; log_ce[log_n]  = nand_ce_n;
         end
         log_n++;
      end
      if (!prev_re && nand_re_n) begin
         if (lo_len != 2) width_bad++;
         lo_len = 0;
         re_cnt++;
      end
      if (prev_re && !nand_re_n) begin
         nand_dq_i = rd_byte(rd_ctr);
         rd_ctr++;
      end
      if (watch_rb && !nand_rb && (!nand_we_n || !nand_re_n)) rb_viol = 1;
      prev_we = nand_we_n;
      prev_re = nand_re_n;
      if (busy_cnt > 0) begin nand_rb = 1'b0; busy_cnt--; end
      else nand_rb = 1'b1;
   end

   // expected model
   logic        exp_cle [0:15];
   logic        exp_ale [0:15];
   logic [7:0]  exp_dq  [0:15];
   string       exp_tag [0:15];
   int          exp_n;
   bit          ce_on_m = 0;
   int          ce_sel_m = 0;

   task automatic push(input logic c, input logic a, input logic [7:0] d, input string t);
      exp_cle[exp_n] = c; exp_ale[exp_n] = a; exp_dq[exp_n] = d; exp_tag[exp_n] = t;
      exp_n++;
   endtask

   task automatic build(input logic [31:0] a, input logic [31:0] wd, input bit wr);
      int n;
      exp_n = 0;
      if (!a[19]) begin
         push(1'b1, 1'b0, a[10:3], "R3");
         n = int'(a[23:21]);
         if (n > 4) n = 4;
         for (int i = 0; i < n; i++) push(1'b0, 1'b1, wd[i*8 +: 8], "R4");
      end else if (wr) begin
         for (int i = 0; i < 4; i++) push(1'b0, 1'b0, wd[i*8 +: 8], "R6");
      end
      if (a[20]) push(1'b1, 1'b0, a[18:11], "R5");
   endtask

   function automatic logic [NC-1:0] ce_exp();
      return ce_on_m ? ~(NC'(1) << ce_sel_m) : {NC{1'b1}};
   endfunction

   task automatic do_req(input logic [31:0] a, input logic [31:0] wd, input bit wr,
                         input int busy_after);
      int cyc;
      int rd0;
      logic [31:0] rexp;
      logic [31:0] got;
      build(a, wd, wr);
      rd0 = rd_ctr;
      @(negedge clk);
      log_n = 0; re_cnt = 0; width_bad = 0;
      h_addr = a; h_wdata = wd; h_write = wr; h_valid = 1'b1;
      ce_on_m = 1; ce_sel_m = int'(a[25:24]);
      cyc = 0;
      do begin @(negedge clk); cyc++; end while (!h_ready && cyc < 3000);
      chk(h_ready, "R11", "completion pulse", {63'd0, h_ready}, 64'd1);
      got = h_rdata;
      h_valid = 1'b0;
      if (a[20]) busy_cnt = busy_after;
      @(negedge clk);
      chk(!h_ready, "R11", "ready single cycle", {63'd0, h_ready}, 64'd0);
      if (a[19] && a[21]) ce_on_m = 0;
      chk(nand_ce_n == ce_exp(), "R8", "chip enable after transfer",
          64'(nand_ce_n), 64'(ce_exp()));
      chk(log_n == exp_n, a[19] ? "R6" : "R4", "latched byte count",
          64'(log_n), 64'(exp_n));
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         chk(log_cle[i] == exp_cle[i] && log_ale[i] == exp_ale[i] && log_dq[i] == exp_dq[i],
             exp_tag[i], "latched byte {cle,ale,dq}",
             {54'd0, log_cle[i], log_ale[i], log_dq[i]},
             {54'd0, exp_cle[i], exp_ale[i], exp_dq[i]});
         chk(log_ce[i] == ~(NC'(1) << a[25:24]), "R2", "chip enable during byte",
             64'(log_ce[i]), 64'(~(NC'(1) << a[25:24])));
      end
      if (a[19] && !wr) begin
         for (int i = 0; i < 4; i++) rexp[i*8 +: 8] = rd_byte(rd0 + i);
         chk(re_cnt == 4, "R7", "read strobe count", 64'(re_cnt), 64'd4);
         chk(got == rexp, "R7", "read word", 64'(got), 64'(rexp));
      end else begin
         chk(re_cnt == 0, "R7", "no read strobes", 64'(re_cnt), 64'd0);
      end
      chk(width_bad == 0, "R10", "strobe widths", 64'(width_bad), 64'd0);
   endtask

   function automatic logic [31:0] mk(input int chip, input bit data, input logic [7:0] op,
                                     input int nadr, input bit endv, input logic [7:0] eop,
                                     input bit rel);
      logic [31:0] a = '0;
      a[31:24] = 8'(chip);
      a[19] = data;
      a[20] = endv;
      a[18:11] = eop;
      if (data) a[21] = rel;
      else begin a[10:3] = op; a[23:21] = 3'(nadr); end
      return a;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(nand_ce_n == {NC{1'b1}} && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !h_ready,
          "R1", "reset outputs",
          {56'd0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale},
          {56'd0, {NC{1'b1}}, 4'b1100});
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: opcode only, h_write ignored in command phase
      do_req(mk(0, 0, 8'h70, 0, 0, 8'h00, 0), 32'h0, 1'b0, 0);
      // R4: five requested address bytes capped at four, closing opcode R5
      do_req(mk(2, 0, 8'h00, 5, 1, 8'h30, 0), 32'hA1B2C3D4, 1'b1, 0);
      // R9: next data read must wait while busy is held low
      watch_rb = 1; rb_viol = 0;
      busy_cnt = 25;
      do_req(mk(2, 1, 8'h00, 0, 0, 8'h00, 0), 32'h0, 1'b0, 0);
      chk(!rb_viol, "R9", "strobe while device busy", {63'd0, rb_viol}, 64'd0);
      watch_rb = 0;
      // R8: data write without release keeps CE, then upper chip bits ignored (R2)
      do_req(mk(1, 1, 8'h00, 0, 0, 8'h00, 0), 32'h11223344, 1'b1, 0);
      do_req(mk(8'hF1, 1, 8'h00, 0, 0, 8'h00, 1), 32'hCAFE0001, 1'b1, 0);
      // R8: command with address count bit 21 set does not release
      do_req(mk(3, 0, 8'h90, 1, 0, 8'h00, 0), 32'h000000EE, 1'b1, 0);
      // R5 on a data read with release
      do_req(mk(3, 1, 8'h00, 0, 1, 8'hE0, 1), 32'h0, 1'b0, 6);

      for (int k = 0; k < 80; k++) begin
         bit dp, wr, ev, rl;
         int ch, na, bz;
         logic [31:0] a;
         dp = 1'($urandom_range(0, 1));
         wr = dp ? 1'($urandom_range(0, 1)) : 1'b1;
         ev = 1'($urandom_range(0, 1));
         rl = 1'($urandom_range(0, 1));
         ch = int'($urandom_range(0, 255));
         na = int'($urandom_range(0, 7));
         bz = int'($urandom_range(0, 12));
         a = mk(ch, dp, 8'($urandom), na, ev, 8'($urandom), rl);
         do_req(a, $urandom, wr, bz);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule